// File: doc/BRIEF.md
# Manchester Transmit Encoder with Selectable Idle

This block turns a serial NRZ data stream into a Manchester-coded symbol stream. It runs from a 20 MHz reference clock and divides that clock into a 10 MHz bit clock. The transmit-enable request and the data input are captured once per bit, at the bit boundary, so a symbol never changes partway through. While a captured enable is active, every bit goes out as a pair of half-bit levels on two complementary digital outputs. These outputs stand for the positive and negative legs of a differential line driver.

When the captured enable is low, the pair sits in an idle condition. A mode bit picks that condition. One choice drives both legs low, giving no differential, which suits a transformer-coupled load. The other holds a steady logical high. The mode bit is kept in a small register that is written through a synchronous write port. The divided bit clock is also an output, so other logic can use it as a bit-rate timing reference.

Top module: `manch_tx_encoder`

## Requirements
- R1: While rst_n is low, tx_pos, tx_neg and bit_clk are all low, and the idle select is cleared to the zero-differential choice.
- R2: bit_clk changes level on every reference clock edge. It is low during the first half of each bit and high during the second half, so one bit lasts two reference cycles.
- R3: A captured data one is sent as tx_pos low in the first half-bit and high in the second half-bit, giving a rising mid-bit transition.
- R4: A captured data zero is sent as tx_pos high in the first half-bit and low in the second half-bit.
- R5: While a bit is being encoded, tx_neg is always the inverse of tx_pos.
- R6: When no bit is being encoded and the idle select is 0, tx_pos and tx_neg are both low.
- R7: When no bit is being encoded and the idle select is 1, tx_pos is high and tx_neg is low. The idle select has no effect on a bit that is being encoded.
- R8: tx_en_req and tx_data are sampled only in the last reference cycle of a bit, and the sampled values govern the whole next bit. A change on either input at any other time leaves the current symbol unchanged. If enable drops partway through a bit, that bit is still finished in full.
- R9: A write with cfg_we high and cfg_addr equal to 15 loads the idle select from cfg_wdata bit 9, and the new value applies from the next cycle. A write to any other address does not change the idle select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_req | input | 1 | Transmit enable request |
| tx_data | input | 1 | Serial NRZ data to send |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_addr | input | 4 | Mode register write address |
| cfg_wdata | input | 16 | Mode register write data; bit 9 is the idle select |
| bit_clk | output | 1 | Divided bit clock; low in the first half-bit |
| tx_pos | output | 1 | Positive leg of the encoded output |
| tx_neg | output | 1 | Negative leg of the encoded output |

## Verification
The bench uses the default parameters: one reference cycle per half-bit, a 4-bit address with the mode register at 15, and 16-bit write data with the idle select at bit 9. With these values each bit is exactly two reference cycles long. Each half-bit can therefore be checked at a known falling edge. Directed tests use this to drop enable or change data partway through a bit, and to reset in the middle of a transmission. Building with a longer half-bit selects the counter-based timer. That changes only how many cycles a half-bit spans, not the encoding rules that the assertions check.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // Level of the positive leg for one half of a Manchester symbol.
  // The first half carries the inverted data and the second half the data,
  // so a one rises at mid-bit and a zero falls.
  function automatic logic manch_half_level(input logic data, input logic second_half);
    return second_half ? data : ~data;
  endfunction

  // Idle levels {pos, neg} for the selected idle choice.
  function automatic logic [1:0] idle_levels(input logic idle_high);
    return idle_high ? 2'b10 : 2'b00;
  endfunction

endpackage

// File: rtl/mtx_bit_timer.sv
module mtx_bit_timer #(
  parameter int REF_PER_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic half_end,
  output logic boundary
);

  logic phase_q;

  generate
    if (REF_PER_HALF == 1) begin : g_toggle
      assign half_end = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(REF_PER_HALF);
      localparam logic [CW-1:0] LAST = CW'(REF_PER_HALF - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign half_end = (cnt_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (half_end) phase_q <= ~phase_q;
  end

  assign phase    = phase_q;
  assign boundary = phase_q & half_end;

endmodule

// File: rtl/mtx_capture.sv
module mtx_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic en_in,
  input  logic data_in,
  output logic active,
  output logic data_q
);

  // Inputs are taken in only at the bit boundary; they then stay fixed for a whole bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      data_q <= 1'b0;
    end else if (boundary) begin
      active <= en_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/mtx_mode_reg.sv
module mtx_mode_reg #(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int MODE_ADDR = 15,
  parameter int IDLE_BIT  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          idle_high
);

  localparam logic [AW-1:0] HIT = AW'(MODE_ADDR);

  logic mode_hit;
  logic unused_wdata;

  assign mode_hit     = we && (addr == HIT);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_high <= 1'b0;
    else if (mode_hit) idle_high <= wdata[IDLE_BIT];
  end

endmodule

// File: rtl/mtx_line_drive.sv
module mtx_line_drive (
  input  logic active,
  input  logic data_q,
  input  logic phase,
  input  logic idle_high,
  output logic pos,
  output logic neg
);
  import mtx_pkg::*;

  logic [1:0] idle_pair;
  logic       sym_level;

  assign idle_pair = idle_levels(idle_high);
  assign sym_level = manch_half_level(data_q, phase);

  always_comb begin
    if (active) begin
      pos = sym_level;
      neg = ~sym_level;
    end else begin
      pos = idle_pair[1];
      neg = idle_pair[0];
    end
  end

endmodule

// File: rtl/manch_tx_encoder.sv
module manch_tx_encoder #(
  parameter int REF_PER_HALF = 1,
  parameter int CFG_AW       = 4,
  parameter int CFG_DW       = 16,
  parameter int MODE_ADDR    = 15,
  parameter int IDLE_BIT     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_req,
  input  logic              tx_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              bit_clk,
  output logic              tx_pos,
  output logic              tx_neg
);

  // Named internal events, brought out for the bound checker.
  logic phase_w;
  logic half_end_w;
  logic boundary_w;
  logic sym_active;
  logic sym_data;
  logic idle_sel;

  mtx_bit_timer #(.REF_PER_HALF(REF_PER_HALF)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_w),
    .half_end (half_end_w),
    .boundary (boundary_w)
  );

  mtx_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary_w),
    .en_in    (tx_en_req),
    .data_in  (tx_data),
    .active   (sym_active),
    .data_q   (sym_data)
  );

  mtx_mode_reg #(
    .AW(CFG_AW), .DW(CFG_DW), .MODE_ADDR(MODE_ADDR), .IDLE_BIT(IDLE_BIT)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .idle_high (idle_sel)
  );

  mtx_line_drive u_drive (
    .active    (sym_active),
    .data_q    (sym_data),
    .phase     (phase_w),
    .idle_high (idle_sel),
    .pos       (tx_pos),
    .neg       (tx_neg)
  );

  assign bit_clk = phase_w;

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
  parameter int CFG_AW    = 4,
  parameter int CFG_DW    = 16,
  parameter int MODE_ADDR = 15,
  parameter int IDLE_BIT  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_clk,
  input logic              tx_pos,
  input logic              tx_neg,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic              half_end,
  input logic              boundary,
  input logic              active,
  input logic              idle_sel
);

  a_r2_bitclk_flips: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |=> bit_clk != $past(bit_clk));

  a_r3_midbit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_clk && half_end) |=> tx_pos != $past(tx_pos));

  a_r5_legs_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tx_neg == !tx_pos));

  a_r6_idle_zero_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !idle_sel) |-> (!tx_pos && !tx_neg));

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && idle_sel) |-> (tx_pos && !tx_neg));

  a_r8_hold_midbit: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active));

  a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(MODE_ADDR)) |=> idle_sel == $past(cfg_wdata[IDLE_BIT]));

endmodule

bind manch_tx_encoder mtx_checker #(
  .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MODE_ADDR(MODE_ADDR), .IDLE_BIT(IDLE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_clk   (bit_clk),
  .tx_pos    (tx_pos),
  .tx_neg    (tx_neg),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .half_end  (half_end_w),
  .boundary  (boundary_w),
  .active    (sym_active),
  .idle_sel  (idle_sel)
);

// File: tb/manch_tx_encoder_bench.sv
module manch_tx_encoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en_req;
  logic        tx_data;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        bit_clk;
  logic        tx_pos;
  logic        tx_neg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  manch_tx_encoder u_manch_tx_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en_req(tx_en_req), .tx_data(tx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bit_clk(bit_clk), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  // Each entry: {sel, en, dat, first-half {pos,neg}, second-half {pos,neg}}
  localparam logic [6:0] VEC [14] = '{
    7'b000_00_00,  // R6 idle zero
    7'b011_01_10,  // R3 one
    7'b010_10_01,  // R4 zero
    7'b011_01_10,  // R3
    7'b011_01_10,  // R3 repeated one
    7'b001_00_00,  // R6 data ignored while idle
    7'b100_10_10,  // R7 idle high
    7'b110_10_01,  // R4 zero, R7 sel ignored while active
    7'b111_01_10,  // R3 one, sel ignored
    7'b100_10_10,  // R7
    7'b000_00_00,  // R6 back to zero differential
    7'b110_10_01,  // R4
    7'b011_01_10,  // R3
    7'b000_00_00   // R6
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic mode_write(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_en_req = 1'b0; tx_data = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {tx_pos, tx_neg}, 2'b00);
    check("R1 reset bit_clk", {1'b0, bit_clk}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 bit_clk second half", {1'b0, bit_clk}, 2'b01);

    // Vector table: each entry starts at a falling edge in a second half-bit.
    for (int i = 0; i < 14; i++) begin
      mode_write(4'd15, 16'(VEC[i][6]) << 9);
      tx_en_req = VEC[i][5];
      tx_data   = VEC[i][4];
      @(negedge clk);
      cfg_we = 1'b0;
      check("R3/R4/R6/R7 first half", {tx_pos, tx_neg}, VEC[i][3:2]);
      check("R2 bit_clk low first half", {1'b0, bit_clk}, 2'b00);
      @(negedge clk);
      check("R3/R4/R5/R6/R7 second half", {tx_pos, tx_neg}, VEC[i][1:0]);
      check("R2 bit_clk high second half", {1'b0, bit_clk}, 2'b01);
    end

    // R8: enable and data drop mid-bit; the bit finishes in full.
    tx_en_req = 1'b1; tx_data = 1'b1;
    @(negedge clk);
    check("R8 bit started", {tx_pos, tx_neg}, 2'b01);
    tx_en_req = 1'b0; tx_data = 1'b0;
    @(negedge clk);
    check("R8 bit finished after enable drop", {tx_pos, tx_neg}, 2'b10);
    @(negedge clk);
    check("R6 idle after drop", {tx_pos, tx_neg}, 2'b00);
    @(negedge clk);

    // R8: data change mid-bit has no effect on the current symbol.
    tx_en_req = 1'b1; tx_data = 1'b0;
    @(negedge clk);
    tx_data = 1'b1;
    check("R8 zero first half", {tx_pos, tx_neg}, 2'b10);
    @(negedge clk);
    tx_en_req = 1'b0; tx_data = 1'b0;
    check("R8 data change mid-bit ignored", {tx_pos, tx_neg}, 2'b01);

    // R8: enable raised only during a first half-bit is never sampled.
    @(negedge clk);
    tx_en_req = 1'b1;
    check("R6 idle", {tx_pos, tx_neg}, 2'b00);
    @(negedge clk);
    tx_en_req = 1'b0;
    @(negedge clk);
    check("R8 short enable ignored first half", {tx_pos, tx_neg}, 2'b00);
    @(negedge clk);
    check("R8 short enable ignored second half", {tx_pos, tx_neg}, 2'b00);

    // R9: write to another address leaves idle select unchanged.
    mode_write(4'd3, 16'h0200);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 other address ignored", {tx_pos, tx_neg}, 2'b00);
    @(negedge clk);
    check("R9 other address ignored later", {tx_pos, tx_neg}, 2'b00);

    // R9: correct address sets select; bit 8 alone clears it.
    mode_write(4'd15, 16'h0200);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 select set from bit 9", {tx_pos, tx_neg}, 2'b10);
    mode_write(4'd15, 16'h0100);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 bit 8 alone clears select", {tx_pos, tx_neg}, 2'b00);

    // R1: reset during a transmission returns to zero-differential idle.
    mode_write(4'd15, 16'h0200);
    tx_en_req = 1'b1; tx_data = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check("R3 active before reset", {tx_pos, tx_neg}, 2'b10);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid transmission", {tx_pos, tx_neg}, 2'b00);
    check("R1 reset bit_clk", {1'b0, bit_clk}, 2'b00);
    tx_en_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 select cleared by reset", {tx_pos, tx_neg}, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule